// File: doc/BRIEF.md
# Halfword-Swapping DMA Write Bridge

This bridge moves a byte stream from a peripheral into memory. The peripheral hands over one command holding a start address, a byte count and a mode bit, then supplies the bytes on a valid/ready stream. The bridge forms the memory address by OR-ing the command address with a base register value and issues write requests on a request channel. A request is a burst of byte beats. Every beat of a burst carries the burst's address and length, and the final beat is flagged.

The mode bit chooses between two paths. In plain mode the bytes go out in arrival order as a single request covering the whole count. In swap mode the peripheral is treated as a 16-bit device. The low address bit and the low count bit are cleared. The two bytes of each halfword are exchanged on their way to memory. The transfer is cut into requests no larger than a configurable chunk size, which is 64 bytes by default. A one-cycle completion pulse marks the end of every command, including a command whose count is zero after masking.

Top module: `dma_hswap_bridge`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `in_ready`, `mem_valid` and `done` are 0.
- R2: The first request of a command carries `cmd_addr | base_addr`, a bitwise OR rather than a sum. In swap mode bit 0 of that value is then cleared.
- R3: `cmd_swap` = 1 selects swap mode. In this mode bit 0 of the address and bit 0 of the byte count are cleared before the transfer starts, and the peripheral supplies exactly the masked count of bytes.
- R4: In swap mode, memory byte 2k is input byte 2k+1 and memory byte 2k+1 is input byte 2k, for every halfword k.
- R5: In swap mode the transfer is split into requests of at most CHUNK_BYTES bytes each. Every request except the last is exactly CHUNK_BYTES long. Each request's address is the previous request's address plus the previous request's length.
- R6: `cmd_swap` = 0 selects plain mode. The transfer is one request whose length equals `cmd_len`, and the bytes reach memory in arrival order, unchanged.
- R7: A beat offered with `mem_valid` = 1 and `mem_ready` = 0 is offered again in the next cycle with the same address, length, data and last flag. All beats of a request carry the same `mem_addr` and `mem_len`. `mem_last` is 1 exactly on the request's final beat, and the next request starts only after that beat is accepted.
- R8: A command whose byte count is zero after masking produces `done` in the cycle after the command is accepted, and no request is issued.
- R9: `done` is 1 for exactly one cycle, in the cycle after the final beat of the final request is accepted.
- R10: `cmd_ready` is 0 for the whole time a transfer is in progress. In particular, it is never 1 while `mem_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_addr | input | AW | High address bits OR-ed into every command address |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted (bridge idle) |
| cmd_addr | input | AW | Peripheral start address |
| cmd_len | input | LW | Byte count |
| cmd_swap | input | 1 | 1 = swap mode, 0 = plain mode |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte taken |
| in_data | input | 8 | Input byte |
| mem_valid | output | 1 | Write beat offered |
| mem_ready | input | 1 | Memory takes the beat |
| mem_addr | output | AW | Start address of the current request |
| mem_len | output | LW | Byte length of the current request |
| mem_data | output | 8 | Beat data byte |
| mem_last | output | 1 | Final beat of the current request |
| done | output | 1 | One-cycle completion pulse |

## Verification
The plain path is tried with an odd count and with an address whose bits overlap the base value. The overlap exposes the difference between an OR merge and an add. The swap path is tried with an odd address and a count of several chunks with a short tail, with a count of exactly two chunks, and with a small odd count. These runs separate masking, byte exchange and chunk stepping. Both paths are also run while memory stalls and the source leaves gaps, to show that requests are held and that data keeps its order under back-pressure. Counts of 0 in plain mode and 1 in swap mode confirm that completion is signalled without any request.

// File: rtl/dma_hswap_pkg.sv
package dma_hswap_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic {
      SEQ_IDLE,
      SEQ_RUN
   } seq_state_e;

   typedef enum logic [1:0] {
      LANE_TAKE_LO,
      LANE_TAKE_HI,
      LANE_EMIT_HI,
      LANE_EMIT_LO
   } lane_state_e;

endpackage

// File: rtl/dma_hswap_chunk.sv
// Combinational sizer: length of the request that starts at the current
// position, and whether that request closes the transfer.
module dma_hswap_chunk #(
   parameter int LW           = 16,
   parameter int CHUNK_BYTES  = 64,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic [LW-1:0] remain,
   input  logic          swap_mode,
   output logic [LW-1:0] chunk_len,
   output logic          is_final
);

   localparam logic [LW-1:0] CHUNK_L = LW'(CHUNK_BYTES);

   generate
      if (SWAP_SUPPORT) begin : g_split
         always_comb begin
            if (swap_mode && (remain > CHUNK_L)) chunk_len = CHUNK_L;
            else                                 chunk_len = remain;
         end
      end else begin : g_whole
         logic unused_mode;
         assign unused_mode = swap_mode;
         assign chunk_len   = remain;
      end
   endgenerate

   assign is_final = (chunk_len == remain);

endmodule

// File: rtl/dma_hswap_lane.sv
// Byte lane: pass-through in plain mode, halfword byte exchange in swap mode.
module dma_hswap_lane
   import dma_hswap_pkg::*;
#(
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              swap_en,
   input  logic              more,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   input  logic              out_ready
);

   generate
      if (SWAP_SUPPORT) begin : g_swap
         lane_state_e       st_q;
         logic [BYTE_W-1:0] lo_q;
         logic [BYTE_W-1:0] hi_q;
         logic              sw_in_ready;
         logic              sw_out_valid;
         logic              in_fire;
         logic              out_fire;

         always_comb begin
            sw_in_ready  = 1'b0;
            sw_out_valid = 1'b0;
            unique case (st_q)
               LANE_TAKE_LO, LANE_TAKE_HI: sw_in_ready = enable;
               LANE_EMIT_HI:               sw_out_valid = enable;
               LANE_EMIT_LO: begin
                  sw_out_valid = enable;
                  sw_in_ready  = enable & out_ready & more;
               end
               default: ;
            endcase
         end

         assign in_fire  = swap_en & in_valid & sw_in_ready;
         assign out_fire = swap_en & sw_out_valid & out_ready;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q <= LANE_TAKE_LO;
               lo_q <= '0;
               hi_q <= '0;
            end else begin
               unique case (st_q)
                  LANE_TAKE_LO: if (in_fire) begin
                     lo_q <= in_data;
                     st_q <= LANE_TAKE_HI;
                  end
                  LANE_TAKE_HI: if (in_fire) begin
                     hi_q <= in_data;
                     st_q <= LANE_EMIT_HI;
                  end
                  LANE_EMIT_HI: if (out_fire) st_q <= LANE_EMIT_LO;
                  LANE_EMIT_LO: if (out_fire) begin
                     if (in_fire) begin
                        lo_q <= in_data;
                        st_q <= LANE_TAKE_HI;
                     end else begin
                        st_q <= LANE_TAKE_LO;
                     end
                  end
                  default: st_q <= LANE_TAKE_LO;
               endcase
            end
         end

         always_comb begin
            if (swap_en) begin
               in_ready  = sw_in_ready;
               out_valid = sw_out_valid;
               out_data  = (st_q == LANE_EMIT_HI) ? hi_q : lo_q;
            end else begin
               in_ready  = enable & out_ready;
               out_valid = enable & in_valid;
               out_data  = in_data;
            end
         end
      end else begin : g_plain
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, swap_en, more};
         assign in_ready  = enable & out_ready;
         assign out_valid = enable & in_valid;
         assign out_data  = in_data;
      end
   endgenerate

endmodule

// File: rtl/dma_hswap_seq.sv
// Command acceptance, address merge, chunk stepping and completion pulse.
module dma_hswap_seq
   import dma_hswap_pkg::*;
#(
   parameter int AW           = 32,
   parameter int LW           = 16,
   parameter int CHUNK_BYTES  = 64,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] base_addr,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic [AW-1:0] cmd_addr,
   input  logic [LW-1:0] cmd_len,
   input  logic          cmd_swap,
   input  logic          beat_fire,
   output logic          run,
   output logic          swap_q,
   output logic [AW-1:0] cur_addr,
   output logic [LW-1:0] chunk_len,
   output logic          beat_last,
   output logic          xfer_more,
   output logic          done
);

   seq_state_e    st_q;
   logic [LW-1:0] remain_q;
   logic [LW-1:0] beat_cnt_q;
   logic          cmd_fire;
   logic          sel_swap;
   logic [AW-1:0] merged_addr;
   logic [AW-1:0] start_addr;
   logic [LW-1:0] start_len;
   logic          is_final;

   assign cmd_ready   = (st_q == SEQ_IDLE);
   assign run         = (st_q == SEQ_RUN);
   assign cmd_fire    = cmd_valid & cmd_ready;
   assign sel_swap    = SWAP_SUPPORT & cmd_swap;
   assign merged_addr = cmd_addr | base_addr;
   assign start_addr  = sel_swap ? {merged_addr[AW-1:1], 1'b0} : merged_addr;
   assign start_len   = sel_swap ? {cmd_len[LW-1:1], 1'b0} : cmd_len;

   dma_hswap_chunk #(
      .LW          (LW),
      .CHUNK_BYTES (CHUNK_BYTES),
      .SWAP_SUPPORT(SWAP_SUPPORT)
   ) u_chunk (
      .remain   (remain_q),
      .swap_mode(swap_q),
      .chunk_len(chunk_len),
      .is_final (is_final)
   );

   assign beat_last = (beat_cnt_q == chunk_len - LW'(1));
   assign xfer_more = ~(beat_last & is_final);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SEQ_IDLE;
         remain_q   <= '0;
         beat_cnt_q <= '0;
         cur_addr   <= '0;
         swap_q     <= 1'b0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            SEQ_IDLE: if (cmd_fire) begin
               if (start_len == '0) begin
                  done <= 1'b1;
               end else begin
                  st_q       <= SEQ_RUN;
                  cur_addr   <= start_addr;
                  remain_q   <= start_len;
                  swap_q     <= sel_swap;
                  beat_cnt_q <= '0;
               end
            end
            SEQ_RUN: if (beat_fire) begin
               if (beat_last) begin
                  beat_cnt_q <= '0;
                  cur_addr   <= cur_addr + AW'(chunk_len);
                  remain_q   <= remain_q - chunk_len;
                  if (is_final) begin
                     st_q <= SEQ_IDLE;
                     done <= 1'b1;
                  end
               end else begin
                  beat_cnt_q <= beat_cnt_q + LW'(1);
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dma_hswap_bridge.sv
module dma_hswap_bridge
   import dma_hswap_pkg::*;
#(
   parameter int AW           = 32,
   parameter int LW           = 16,
   parameter int CHUNK_BYTES  = 64,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     base_addr,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [AW-1:0]     cmd_addr,
   input  logic [LW-1:0]     cmd_len,
   input  logic              cmd_swap,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BYTE_W-1:0] in_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [AW-1:0]     mem_addr,
   output logic [LW-1:0]     mem_len,
   output logic [BYTE_W-1:0] mem_data,
   output logic              mem_last,
   output logic              done
);

   generate
      if (CHUNK_BYTES < 2 || (CHUNK_BYTES % 2) != 0) begin : g_bad_chunk
         $error("CHUNK_BYTES must be an even value of at least 2");
      end
      if (LW <= $clog2(CHUNK_BYTES)) begin : g_bad_len
         $error("LW too narrow to express CHUNK_BYTES");
      end
      if (AW < 2) begin : g_bad_addr
         $error("AW must be at least 2");
      end
   endgenerate

   logic run;
   logic swap_q;
   logic xfer_more;
   logic beat_fire;

   assign beat_fire = mem_valid & mem_ready;

   dma_hswap_seq #(
      .AW          (AW),
      .LW          (LW),
      .CHUNK_BYTES (CHUNK_BYTES),
      .SWAP_SUPPORT(SWAP_SUPPORT)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_addr(base_addr),
      .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready),
      .cmd_addr (cmd_addr),
      .cmd_len  (cmd_len),
      .cmd_swap (cmd_swap),
      .beat_fire(beat_fire),
      .run      (run),
      .swap_q   (swap_q),
      .cur_addr (mem_addr),
      .chunk_len(mem_len),
      .beat_last(mem_last),
      .xfer_more(xfer_more),
      .done     (done)
   );

   dma_hswap_lane #(
      .SWAP_SUPPORT(SWAP_SUPPORT)
   ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (run),
      .swap_en  (swap_q),
      .more     (xfer_more),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_ready (in_ready),
      .out_valid(mem_valid),
      .out_data (mem_data),
      .out_ready(mem_ready)
   );

endmodule

// File: rtl/dma_hswap_chk.sv
module dma_hswap_chk #(
   parameter int AW           = 32,
   parameter int LW           = 16,
   parameter int CHUNK_BYTES  = 64,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] base_addr,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic [AW-1:0] cmd_addr,
   input logic [LW-1:0] cmd_len,
   input logic          cmd_swap,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic [LW-1:0] mem_len,
   input logic [7:0]    mem_data,
   input logic          mem_last,
   input logic          done
);

   logic          sw_mode;
   logic [AW-1:0] plain_addr;
   logic [LW-1:0] plain_len;
   logic          cmd_take;
   logic          cmd_sw;
   logic          cmd_zero;

   assign cmd_take = cmd_valid & cmd_ready;
   assign cmd_sw   = cmd_swap & SWAP_SUPPORT;
   assign cmd_zero = cmd_sw ? (cmd_len[LW-1:1] == '0) : (cmd_len == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_mode    <= 1'b0;
         plain_addr <= '0;
         plain_len  <= '0;
      end else if (cmd_take) begin
         sw_mode    <= cmd_sw;
         plain_addr <= cmd_addr | base_addr;
         plain_len  <= cmd_len;
      end
   end

   a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len)
                                     && $stable(mem_data) && $stable(mem_last)));

   a_r3_even_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && sw_mode) |-> (!mem_addr[0] && !mem_len[0]));

   a_r5_chunk_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && sw_mode) |-> (mem_len != '0 && mem_len <= LW'(CHUNK_BYTES)));

   a_r6_single_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !sw_mode) |-> (mem_addr == plain_addr && mem_len == plain_len));

   a_r8_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_take && cmd_zero) |=> (done && !mem_valid));

   a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> !cmd_ready);

   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_valid && cmd_ready));

endmodule

bind dma_hswap_bridge dma_hswap_chk #(
   .AW          (AW),
   .LW          (LW),
   .CHUNK_BYTES (CHUNK_BYTES),
   .SWAP_SUPPORT(SWAP_SUPPORT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .base_addr(base_addr),
   .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready),
   .cmd_addr (cmd_addr),
   .cmd_len  (cmd_len),
   .cmd_swap (cmd_swap),
   .mem_valid(mem_valid),
   .mem_ready(mem_ready),
   .mem_addr (mem_addr),
   .mem_len  (mem_len),
   .mem_data (mem_data),
   .mem_last (mem_last),
   .done     (done)
);

// File: tb/test_dma_hswap_bridge.sv
`timescale 1ns/1ps
module test_dma_hswap_bridge;

   localparam int AW = 32;
   localparam int LW = 16;
   localparam int CH = 64;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] base_addr;
   logic          cmd_valid;
   logic          cmd_ready;
   logic [AW-1:0] cmd_addr;
   logic [LW-1:0] cmd_len;
   logic          cmd_swap;
   logic          in_valid;
   logic          in_ready;
   logic [7:0]    in_data;
   logic          mem_valid;
   logic          mem_ready;
   logic [AW-1:0] mem_addr;
   logic [LW-1:0] mem_len;
   logic [7:0]    mem_data;
   logic          mem_last;
   logic          done;

   always #2.5 clk = ~clk;

   dma_hswap_bridge #(.AW(AW), .LW(LW), .CHUNK_BYTES(CH), .SWAP_SUPPORT(1'b1)) i_dma_hswap_bridge (
      .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_len(cmd_len), .cmd_swap(cmd_swap),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_len(mem_len), .mem_data(mem_data), .mem_last(mem_last), .done(done)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   logic [7:0]    src [0:255];
   int            src_n = 0, src_idx = 0, shown = -1;
   logic [7:0]    cap [0:255];
   int            cap_n = 0;
   logic [AW-1:0] ch_addr [0:15];
   logic [LW-1:0] ch_len [0:15];
   int            ch_n = 0, beat_in_ch = 0;
   int            last_acc_cyc = 0, done_cyc = 0, done_cnt = 0, cmd_acc_cyc = 0;
   int            hold_bad = 0, chunk_bad = 0, busy_bad = 0;
   bit            cmd_taken = 0, prev_stall = 0;
   logic [AW-1:0] p_addr;
   logic [LW-1:0] p_len;
   logic [7:0]    p_data;
   logic          p_last;
   int            rdy_mode = 0, gap_mode = 0;

   task automatic chk(input string what, input bit ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
      end
   endtask

   // Monitor: samples half a nanosecond before each rising edge.
   always begin
      @(negedge clk);
      #2;
      cyc++;
      if (rst_n) begin
         if (prev_stall && !(mem_valid && mem_addr == p_addr && mem_len == p_len &&
                             mem_data == p_data && mem_last == p_last)) hold_bad++;
         prev_stall = mem_valid && !mem_ready;
         p_addr = mem_addr; p_len = mem_len; p_data = mem_data; p_last = mem_last;
         if (mem_valid && cmd_ready) busy_bad++;
         if (in_valid && in_ready) src_idx++;
         if (cmd_valid && cmd_ready) begin cmd_taken = 1; cmd_acc_cyc = cyc; end
         if (done) begin done_cnt++; done_cyc = cyc; end
         if (mem_valid && mem_ready) begin
            if (beat_in_ch == 0) begin
               if (ch_n < 16) begin ch_addr[ch_n] = mem_addr; ch_len[ch_n] = mem_len; end
               ch_n++;
            end else if (ch_n <= 16 && (mem_addr != ch_addr[ch_n-1] || mem_len != ch_len[ch_n-1])) begin
               chunk_bad++;
            end
            if (cap_n < 256) cap[cap_n] = mem_data;
            cap_n++;
            beat_in_ch++;
            if ((beat_in_ch == int'(mem_len)) != mem_last) chunk_bad++;
            if (mem_last) begin beat_in_ch = 0; last_acc_cyc = cyc; end
         end
      end
   end

   // Memory ready pattern and byte source, driven on the falling edge.
   always @(negedge clk) begin
      case (rdy_mode)
         1:       mem_ready = cyc[0];
         2:       mem_ready = (cyc % 3) != 0;
         default: mem_ready = 1'b1;
      endcase
      if (src_idx < src_n) begin
         if (in_valid && shown == src_idx) begin
            // keep offering the same byte until taken
         end else if (gap_mode == 0 || (cyc % 3) == 1) begin
            in_valid = 1'b1;
            in_data  = src[src_idx];
            shown    = src_idx;
         end else begin
            in_valid = 1'b0;
         end
      end else begin
         in_valid = 1'b0;
      end
   end

   task automatic run_xfer(input string name, input logic [AW-1:0] a, input logic [AW-1:0] b,
                           input logic [LW-1:0] l, input bit sw, input int rm, input int gm);
      logic [LW-1:0] eff_len;
      logic [AW-1:0] eff_addr;
      logic [AW-1:0] ad;
      int rem, k, bad, first_bad, waited;
      logic [7:0] exp_b, act_b;
      eff_len  = sw ? (l & ~LW'(1)) : l;
      eff_addr = sw ? ((a | b) & ~AW'(1)) : (a | b);
      @(negedge clk);
      cap_n = 0; ch_n = 0; beat_in_ch = 0; done_cnt = 0;
      hold_bad = 0; chunk_bad = 0; busy_bad = 0; cmd_taken = 0;
      rdy_mode = rm; gap_mode = gm;
      for (int i = 0; i < 256; i++) src[i] = 8'(i * 37 + int'(l) + 5);
      src_idx = 0; shown = -1; src_n = int'(eff_len);
      base_addr = b; cmd_addr = a; cmd_len = l; cmd_swap = sw; cmd_valid = 1'b1;
      waited = 0;
      while (!cmd_taken && waited < 100) begin @(negedge clk); waited++; end
      cmd_valid = 1'b0;
      waited = 0;
      while (done_cnt == 0 && waited < 5000) begin @(negedge clk); waited++; end
      chk({name, " R9 transfer completes"}, done_cnt != 0, done_cnt, 1);
      repeat (4) @(negedge clk);
      chk({name, " R9 one done pulse"}, done_cnt == 1, done_cnt, 1);
      chk({name, " R10 cmd_ready low while busy"}, busy_bad == 0, busy_bad, 0);
      if (eff_len == 0) begin
         chk({name, " R8 no request"}, cap_n == 0, cap_n, 0);
         chk({name, " R8 done timing"}, done_cyc == cmd_acc_cyc + 1, done_cyc, cmd_acc_cyc + 1);
      end else begin
         chk({name, " R9 done one cycle after last beat"}, done_cyc == last_acc_cyc + 1,
             done_cyc, last_acc_cyc + 1);
         chk({name, sw ? " R3 masked byte count" : " R6 full byte count"},
             cap_n == int'(eff_len), cap_n, eff_len);
         bad = 0; first_bad = -1; exp_b = 0; act_b = 0;
         for (int i = 0; i < int'(eff_len) && i < 256; i++) begin
            if (cap[i] !== (sw ? src[i ^ 1] : src[i])) begin
               if (first_bad < 0) begin
                  first_bad = i; act_b = cap[i]; exp_b = sw ? src[i ^ 1] : src[i];
               end
               bad++;
            end
         end
         chk({name, sw ? " R4 halfword bytes exchanged" : " R6 data unchanged"},
             bad == 0, act_b, exp_b);
         chk({name, " R2 merged start address"}, ch_addr[0] == eff_addr, ch_addr[0], eff_addr);
         rem = int'(eff_len); ad = eff_addr; k = 0; bad = 0;
         while (rem > 0) begin
            int cl;
            cl = (sw && rem > CH) ? CH : rem;
            if (k < ch_n && k < 16) begin
               if (ch_addr[k] != ad || int'(ch_len[k]) != cl) bad++;
            end
            ad = ad + AW'(cl); rem = rem - cl; k++;
         end
         chk({name, sw ? " R5 request count" : " R6 single request"}, ch_n == k, ch_n, k);
         chk({name, " R5 request addresses and lengths"}, bad == 0, bad, 0);
         chk({name, " R7 stalled beat held"}, hold_bad == 0, hold_bad, 0);
         chk({name, " R7 beats share request fields, last flag"}, chunk_bad == 0, chunk_bad, 0);
      end
      rdy_mode = 0; gap_mode = 0;
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      chk("R1 cmd_ready after reset", cmd_ready == 1'b1, cmd_ready, 1);
      chk("R1 in_ready after reset", in_ready == 1'b0, in_ready, 0);
      chk("R1 mem_valid after reset", mem_valid == 1'b0, mem_valid, 0);
      chk("R1 done after reset", done == 1'b0, done, 0);
   endtask

   task automatic t_plain_odd();
      run_xfer("plain odd count", 32'h0000_1233, 32'h4000_0000, 16'd37, 1'b0, 0, 0);
   endtask

   task automatic t_plain_overlap_stall();
      // OR gives 0x111, a sum would give 0x211
      run_xfer("plain overlap stall", 32'h0000_0101, 32'h0000_0110, 16'd20, 1'b0, 1, 1);
   endtask

   task automatic t_swap_multi();
      run_xfer("swap three chunks", 32'h0000_2001, 32'h8000_0000, 16'd150, 1'b1, 0, 0);
   endtask

   task automatic t_swap_exact_stall();
      run_xfer("swap two full chunks stall", 32'h0000_0400, 32'h1000_0000, 16'd128, 1'b1, 2, 1);
   endtask

   task automatic t_swap_odd_small();
      run_xfer("swap odd small", 32'h0000_0033, 32'h0200_0000, 16'd9, 1'b1, 1, 0);
   endtask

   task automatic t_zero();
      run_xfer("swap len one", 32'h0000_0010, 32'h0000_0000, 16'd1, 1'b1, 0, 0);
      run_xfer("plain len zero", 32'h0000_0020, 32'h0000_0000, 16'd0, 1'b0, 0, 0);
   endtask

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0; cmd_swap = 1'b0;
      base_addr = '0; in_valid = 1'b0; in_data = '0; mem_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_plain_odd();
      t_plain_overlap_stall();
      t_swap_multi();
      t_swap_exact_stall();
      t_swap_odd_small();
      t_zero();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(negedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=expired expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule